// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit repairs a 16-bit accumulator after binary arithmetic has been done on decimal data. The data is either packed, with two digits per byte, or unpacked, with one digit per byte. The accumulator is split into a high byte and a low byte.

The unit supports six operations:
- Add and subtract fix-ups for unpacked digits. These may carry into the high byte or borrow from it.
- Add and subtract fix-ups for packed digits. These change only the low byte.
- A split of the low byte into quotient and remainder by a programmable base. This follows a multiply.
- A merge of two digits into one binary value by the same base. This precedes a divide.

The incoming carry and auxiliary-carry flags feed the fix-up conditions. They are passed through unchanged by every operation that does not define them. A separate error output marks a split requested with a base of zero.

All results are captured in output registers. The result of an input set appears one clock after it is presented.

Top module: `decimal_adjust_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out`, `cf_out`, `af_out` and `div_err` are cleared to zero on that edge.
- R2: For `op_sel` = 0 (unpacked add fix-up), the condition is: the low nibble of the low byte exceeds 9, or `af_in` is 1.
  - When the condition holds, 6 is added to the full 16-bit accumulator, the high byte of that sum is then incremented, and both flags are set.
  - Otherwise the high byte is kept and both flags are cleared.
  - In both cases the low byte keeps only its low nibble.
- R3: For `op_sel` = 2 (unpacked subtract fix-up), the condition is the same as in R2.
  - When it holds, 6 is subtracted from the low byte alone, 1 is subtracted from the high byte, and both flags are set.
  - Otherwise the high byte is kept and both flags are cleared.
  - The low byte then keeps only its low nibble.
- R4: For `op_sel` = 1 (packed add fix-up), two steps run in order:
  - If the low nibble exceeds 9 or `af_in` is 1, add 6 to the low byte and set AF.
  - Then, if the new low byte exceeds 0x9F or `cf_in` is 1, add 0x60 to it and set CF.
  - A flag whose step does not fire keeps its input value. The high byte is unchanged.
- R5: For `op_sel` = 3 (packed subtract fix-up), the same two steps and conditions as R4 apply, with 6 and 0x60 subtracted instead of added. The high byte is unchanged.
- R6: For `op_sel` = 4 (split) with a nonzero `base`, the high byte becomes the low byte divided by `base`, and the low byte becomes the low byte modulo `base`. Any base from 1 to 255 is honoured, 10 being the usual one.
- R7: For `op_sel` = 4 with `base` = 0, `div_err` is 1 and the accumulator and both flags are returned unchanged. `div_err` is 0 after every other operation.
- R8: For `op_sel` = 5 (merge), the low byte becomes the low 8 bits of high byte × `base` + low byte, and the high byte becomes 0.
- R9: For `op_sel` 4 and 5, `cf_out` and `af_out` equal `cf_in` and `af_in`. For `op_sel` 6 and 7, the accumulator and both flags pass through unchanged.
- R10: Outputs change only on a clock edge and reflect the inputs present at that edge. Changing the inputs between edges leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (0 to 7, see requirements) |
| acc_in | input | 16 | Accumulator: high byte in [15:8], low byte in [7:0] |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| base | input | 8 | Base for the split and merge operations |
| acc_out | output | 16 | Corrected accumulator, registered |
| cf_out | output | 1 | Updated carry flag, registered |
| af_out | output | 1 | Updated auxiliary-carry flag, registered |
| div_err | output | 1 | Split requested with a zero base, registered |

## Verification
The bench sweeps every low-byte value against all four flag combinations and three high-byte values. This reaches the following corners, each with the symptom of a faulty design:
- **Low byte 0xFA to 0xFF in the unpacked add.** A design that adds 6 to the low byte alone drops the carry into the high byte, leaving it one short.
- **Packed fix-ups where the first step pushes the byte past 0x9F.** A design that tests the original byte misses the second correction.
- **Flag inputs already set while the nibble is in range.** A design that ignores them neither corrects the value nor keeps the flags.

The split and merge are swept over bases 0, 1, 255 and 10, along with several others. This exposes a divide by zero that corrupts the accumulator, and a merge that does not wrap its product to 8 bits.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  typedef enum logic [2:0] {
    OP_UNP_ADD = 3'd0,
    OP_PK_ADD  = 3'd1,
    OP_UNP_SUB = 3'd2,
    OP_PK_SUB  = 3'd3,
    OP_SPLIT   = 3'd4,
    OP_MERGE   = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } adj_op_e;
endpackage

// File: rtl/dadj_addsub.sv
module dadj_addsub #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] hi_in,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic              cf_in,
  input  logic              af_in,
  input  logic              is_sub,
  input  logic              is_packed,
  output logic [BYTE_W-1:0] hi_out,
  output logic [BYTE_W-1:0] lo_out,
  output logic              cf_out,
  output logic              af_out
);
  localparam int NIB_W = 4;
  localparam logic [BYTE_W-1:0] SIX    = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] SIXTY  = BYTE_W'('h60);
  localparam logic [BYTE_W-1:0] HI_LIM = BYTE_W'('h9F);
  localparam logic [BYTE_W-1:0] ONE    = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] NIB_MASK = BYTE_W'((1 << NIB_W) - 1);
  localparam logic [BYTE_W-1:0] WRAP6  = {BYTE_W{1'b1}} - SIX;

  logic              low_fix;
  logic              high_fix;
  logic              carry6;
  logic [BYTE_W-1:0] lo_step1;
  logic [BYTE_W-1:0] lo_step2;
  logic [BYTE_W-1:0] hi_unp;
  logic [BYTE_W-1:0] lo_unp;

  always_comb begin
    low_fix = (lo_in[NIB_W-1:0] > NIB_W'(9)) | af_in;
    carry6  = (lo_in > WRAP6);

    // unpacked path: add spans the full accumulator, subtract only the low byte
    if (!low_fix) begin
      hi_unp = hi_in;
      lo_unp = lo_in & NIB_MASK;
    end else if (is_sub) begin
      hi_unp = hi_in - ONE;
      lo_unp = (lo_in - SIX) & NIB_MASK;
    end else begin
      hi_unp = hi_in + {{(BYTE_W-1){1'b0}}, carry6} + ONE;
      lo_unp = (lo_in + SIX) & NIB_MASK;
    end

    // packed path: two ordered steps, second tests the result of the first
    if (low_fix) lo_step1 = is_sub ? (lo_in - SIX) : (lo_in + SIX);
    else         lo_step1 = lo_in;
    high_fix = (lo_step1 > HI_LIM) | cf_in;
    if (high_fix) lo_step2 = is_sub ? (lo_step1 - SIXTY) : (lo_step1 + SIXTY);
    else          lo_step2 = lo_step1;

    if (is_packed) begin
      hi_out = hi_in;
      lo_out = lo_step2;
      af_out = low_fix;
      cf_out = high_fix;
    end else begin
      hi_out = hi_unp;
      lo_out = lo_unp;
      af_out = low_fix;
      cf_out = low_fix;
    end
  end
endmodule

// File: rtl/dadj_base.sv
module dadj_base #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] hi_in,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] base,
  input  logic              is_merge,
  output logic [BYTE_W-1:0] hi_out,
  output logic [BYTE_W-1:0] lo_out,
  output logic              zero_base
);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  logic [BYTE_W-1:0] safe_base;

  always_comb begin
    zero_base = (base == '0) && !is_merge;
    safe_base = (base == '0) ? ONE : base;
    if (is_merge) begin
      hi_out = '0;
      lo_out = hi_in * base + lo_in;
    end else if (zero_base) begin
      hi_out = hi_in;
      lo_out = lo_in;
    end else begin
      hi_out = lo_in / safe_base;
      lo_out = lo_in % safe_base;
    end
  end
endmodule

// File: rtl/decimal_adjust_unit.sv
module decimal_adjust_unit
  import dadj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            op_sel,
  input  logic [2*BYTE_W-1:0]   acc_in,
  input  logic                  cf_in,
  input  logic                  af_in,
  input  logic [BYTE_W-1:0]     base,
  output logic [2*BYTE_W-1:0]   acc_out,
  output logic                  cf_out,
  output logic                  af_out,
  output logic                  div_err
);
  localparam int ACC_W = 2 * BYTE_W;
  localparam int NIB_W = 4;

  logic [BYTE_W-1:0] hi_in, lo_in;
  logic [BYTE_W-1:0] as_hi, as_lo, bs_hi, bs_lo;
  logic              as_cf, as_af, bs_zero;
  logic [ACC_W-1:0]  acc_nxt;
  logic              cf_nxt, af_nxt, err_nxt;

  assign hi_in = acc_in[ACC_W-1:BYTE_W];
  assign lo_in = acc_in[BYTE_W-1:0];

  dadj_addsub #(.BYTE_W(BYTE_W)) u_addsub (
    .hi_in(hi_in), .lo_in(lo_in), .cf_in(cf_in), .af_in(af_in),
    .is_sub(op_sel[1]), .is_packed(op_sel[0]),
    .hi_out(as_hi), .lo_out(as_lo), .cf_out(as_cf), .af_out(as_af)
  );

  dadj_base #(.BYTE_W(BYTE_W)) u_base (
    .hi_in(hi_in), .lo_in(lo_in), .base(base), .is_merge(op_sel[0]),
    .hi_out(bs_hi), .lo_out(bs_lo), .zero_base(bs_zero)
  );

  always_comb begin
    acc_nxt = acc_in;
    cf_nxt  = cf_in;
    af_nxt  = af_in;
    err_nxt = 1'b0;
    case (adj_op_e'(op_sel))
      OP_UNP_ADD, OP_PK_ADD, OP_UNP_SUB, OP_PK_SUB: begin
        acc_nxt = {as_hi, as_lo};
        cf_nxt  = as_cf;
        af_nxt  = as_af;
      end
      OP_SPLIT, OP_MERGE: begin
        acc_nxt = {bs_hi, bs_lo};
        err_nxt = bs_zero;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      cf_out  <= 1'b0;
      af_out  <= 1'b0;
      div_err <= 1'b0;
    end else begin
      acc_out <= acc_nxt;
      cf_out  <= cf_nxt;
      af_out  <= af_nxt;
      div_err <= err_nxt;
    end
  end

  // R2
  unp_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_UNP_ADD || $past(op_sel) == OP_UNP_SUB))
      |-> (acc_out[BYTE_W-1:NIB_W] == '0 && cf_out == af_out));

  // R4
  pk_hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_PK_ADD || $past(op_sel) == OP_PK_SUB))
      |-> acc_out[ACC_W-1:BYTE_W] == $past(acc_in[ACC_W-1:BYTE_W]));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    div_err |-> ($past(op_sel) == OP_SPLIT && $past(base) == '0
                 && acc_out == $past(acc_in)));

  // R8
  merge_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == OP_MERGE)
      |-> (acc_out[ACC_W-1:BYTE_W] == '0 && !div_err));

  // R9
  flag_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel[2]))
      |-> (cf_out == $past(cf_in) && af_out == $past(af_in)));
endmodule

// File: tb/decimal_adjust_unit_tb.sv
`timescale 1ns/1ps
module decimal_adjust_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic [15:0] acc_in = '0;
  logic        cf_in = 1'b0, af_in = 1'b0;
  logic [7:0]  base = 8'd10;
  logic [15:0] acc_out;
  logic        cf_out, af_out, div_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int hv[3] = '{0, 18, 255};
  int bv[9] = '{0, 1, 2, 3, 7, 10, 16, 100, 255};

  always #2 clk = ~clk;

  decimal_adjust_unit u_dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in),
    .cf_in(cf_in), .af_in(af_in), .base(base),
    .acc_out(acc_out), .cf_out(cf_out), .af_out(af_out), .div_err(div_err)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return "R6/R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // expected {acc[15:0], cf, af, err}
  function automatic logic [18:0] model(int op, int ah, int al, int cf, int af, int b);
    int nah = ah, nal = al, ncf = cf, naf = af, err = 0, t;
    bit lowc = ((al % 16) > 9) || (af != 0);
    case (op)
      0: begin
        if (lowc) begin
          t = ah * 256 + al + 6;
          nah = ((t / 256) + 1) % 256; nal = t % 16; ncf = 1; naf = 1;
        end else begin nal = al % 16; ncf = 0; naf = 0; end
      end
      2: begin
        if (lowc) begin
          nah = (ah + 255) % 256; nal = (al + 250) % 16; ncf = 1; naf = 1;
        end else begin nal = al % 16; ncf = 0; naf = 0; end
      end
      1, 3: begin
        t = al;
        if (lowc) begin t = (op == 1) ? (t + 6) % 256 : (t + 250) % 256; naf = 1; end
        if (t > 159 || cf != 0) begin
          t = (op == 1) ? (t + 96) % 256 : (t + 160) % 256; ncf = 1;
        end
        nal = t;
      end
      4: begin
        if (b == 0) err = 1;
        else begin nah = al / b; nal = al % b; end
      end
      5: begin nal = (ah * b + al) % 256; nah = 0; end
      default: ;
    endcase
    return {16'(nah * 256 + nal), 1'(ncf), 1'(naf), 1'(err)};
  endfunction

  task automatic compare(logic [18:0] exp, string req);
    logic [18:0] act = {acc_out, cf_out, af_out, div_err};
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors <= 25)
        $display("FAIL %s op=%0d in=%h cf=%0b af=%0b base=%0d actual=%h expected=%h",
                 req, op_sel, acc_in, cf_in, af_in, base, act, exp);
    end
  endtask

  task automatic run(int op, int ah, int al, int cf, int af, int b);
    op_sel = 3'(op); acc_in = 16'(ah * 256 + al);
    cf_in = 1'(cf); af_in = 1'(af); base = 8'(b);
    @(posedge clk); #1;
    compare(model(op, ah, al, cf, af, b), req_of(op));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with active inputs
    op_sel = 3'd0; acc_in = 16'hFFFF; cf_in = 1'b1; af_in = 1'b1;
    repeat (3) @(posedge clk); #1;
    compare(19'd0, "R1");
    rst = 1'b0;

    // R10: outputs hold between edges
    run(0, 1, 15, 0, 0, 10);
    op_sel = 3'd5; acc_in = 16'h0304;
    #1 compare(model(0, 1, 15, 0, 0, 10), "R10");
    @(posedge clk); #1;
    compare(model(5, 3, 4, 0, 0, 10), "R10");

    // directed corners: carry into high byte, second packed step
    run(0, 5, 250, 0, 0, 10);   // R2
    run(1, 0, 154, 0, 0, 10);   // R4
    run(3, 0, 6, 0, 1, 10);     // R5
    run(4, 0, 81, 1, 0, 10);    // R6
    run(4, 7, 81, 1, 1, 0);     // R7
    run(5, 9, 9, 0, 1, 10);     // R8
    run(5, 255, 255, 1, 0, 255);// R8 wrap

    // R2 R3 R4 R5 sweeps
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a++)
        for (int f = 0; f < 4; f++)
          for (int h = 0; h < 3; h++)
            run(op, hv[h], a, f / 2, f % 2, 10);

    // R6 R7 split sweep
    for (int b = 0; b < 9; b++)
      for (int a = 0; a < 256; a++)
        run(4, 37, a, a % 2, (a / 2) % 2, bv[b]);

    // R8 merge sweep
    for (int b = 0; b < 9; b++)
      for (int h = 0; h < 256; h++) begin
        run(5, h, 0, 1, 0, bv[b]);
        run(5, h, 5, 0, 1, bv[b]);
        run(5, h, 255, 1, 1, bv[b]);
      end

    // R9 reserved codes pass everything
    for (int op = 6; op < 8; op++)
      for (int a = 0; a < 256; a += 17)
        run(op, 255 - a, a, a % 2, 1 - a % 2, a);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule